// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the word address for a short burst in a synchronous burst memory. When either of two active-low address strobes is sampled low on a rising clock edge, the block captures a base address and restarts its beat counter. Each later edge with the active-low advance input sampled low moves to the next beat. While advance is high, the burst is suspended and holds its current beat.

Only the low address bits are sequenced. The upper bits stay at the captured value for the whole burst. A mode pin chooses the order of the low bits. In the XOR order, the low bits are the captured low bits XOR the beat. In the wrapping order, they are the captured low bits plus the beat, modulo the burst length, so the burst stays inside its aligned block.

The block moves no data, so it has no valid/ready stream interface. All of its pins are plain control and address signals. The mode pin acts on the output without a register, so it must be held steady during a burst.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_o` is 0 and `beat_o` is 0.
- R2: If `strobe_cpu_n` or `strobe_ctl_n` is low at a rising edge, then after that edge `addr_o` equals the `base_addr` sampled at the edge, and `beat_o` is 0. Either strobe alone is enough.
- R3: If both strobes are high and `adv_n` is low at a rising edge, `beat_o` increases by 1 modulo 4 at that edge.
- R4: If both strobes are high and `adv_n` is high at a rising edge, `beat_o` and `addr_o` keep their values.
- R5: With `order_lin` = 0 (XOR order), `addr_o[1:0]` equals the captured low two bits XOR `beat_o`. For example, a start of 1 gives 1, 0, 3, 2.
- R6: With `order_lin` = 1 (wrapping order), `addr_o[1:0]` equals the captured low two bits plus `beat_o`, modulo 4. For example, a start of 2 gives 2, 3, 0, 1.
- R7: While both strobes are high, `addr_o[ADDR_W-1:2]` never changes.
- R8: If a strobe and `adv_n` are both low at the same edge, the strobe wins: `beat_o` becomes 0 and `addr_o` takes the new base.
- R9: A fourth advance wraps `beat_o` from 3 to 0, and `addr_o` returns to the captured base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_cpu_n | input | 1 | Active-low address strobe, first source |
| strobe_ctl_n | input | 1 | Active-low address strobe, second source |
| adv_n | input | 1 | Active-low advance; when high, the burst holds |
| order_lin | input | 1 | Burst order: 0 = XOR order, 1 = wrapping order |
| base_addr | input | ADDR_W | Base address, captured on a strobe |
| addr_o | output | ADDR_W | Current burst word address |
| beat_o | output | BEAT_W | Current beat index |

## Verification
The bench builds the block with its default parameters: a 17-bit address and a 2-bit beat field. With a 2-bit beat field, a full wrap takes only four advances, and every start value of the low bits can be driven under both orders. The 15 upper bits are wide enough to carry distinct patterns, so a stray carry out of the sequenced field, or a reload that misses some bits, changes a visible bit.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic {
    ORD_XOR  = 1'b0,
    ORD_WRAP = 1'b1
  } order_e;
endpackage

// File: rtl/bsq_base_reg.sv
module bsq_base_reg #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2,
  localparam int HI_W  = ADDR_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_i,
  output logic [HI_W-1:0]   hi_o,
  output logic [BEAT_W-1:0] lo_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_o <= '0;
      lo_o <= '0;
    end else if (load) begin
      hi_o <= base_i[ADDR_W-1:BEAT_W];
      lo_o <= base_i[BEAT_W-1:0];
    end
  end
endmodule

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     beat_o <= '0;
    else if (clear) beat_o <= '0;
    else if (step)  beat_o <= beat_o + BEAT_W'(1);
  end
endmodule

// File: rtl/bsq_low_map.sv
module bsq_low_map #(
  parameter int BEAT_W = 2
) (
  input  bsq_pkg::order_e   order,
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] lo_o
);
  logic [BEAT_W-1:0] xor_lo;
  logic [BEAT_W-1:0] wrap_lo;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
    assign xor_lo[b] = start_lo[b] ^ beat[b];
  end

  assign wrap_lo = start_lo + beat;

  always_comb begin
    unique case (order)
      bsq_pkg::ORD_WRAP: lo_o = wrap_lo;
      default:           lo_o = xor_lo;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2,
  localparam int HI_W  = ADDR_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              adv_n,
  input  logic              order_lin,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] beat_o
);
  logic              load;
  logic              step;
  logic [HI_W-1:0]   hi_q;
  logic [BEAT_W-1:0] lo_q;
  logic [BEAT_W-1:0] lo_seq;
  bsq_pkg::order_e   order;

  // A strobe outranks advance on the same edge.
  assign load  = ~strobe_cpu_n | ~strobe_ctl_n;
  assign step  = ~adv_n & ~load;
  assign order = bsq_pkg::order_e'(order_lin);

  bsq_base_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_base (
    .clk(clk), .rst_n(rst_n), .load(load), .base_i(base_addr),
    .hi_o(hi_q), .lo_o(lo_q)
  );

  bsq_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clear(load), .step(step), .beat_o(beat_o)
  );

  bsq_low_map #(.BEAT_W(BEAT_W)) u_map (
    .order(order), .start_lo(lo_q), .beat(beat_o), .lo_o(lo_seq)
  );

  assign addr_o = {hi_q, lo_seq};
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe_cpu_n,
  input logic              strobe_ctl_n,
  input logic              adv_n,
  input logic              order_lin,
  input logic [ADDR_W-1:0] base_addr,
  input logic [ADDR_W-1:0] addr_o,
  input logic [BEAT_W-1:0] beat_o
);
  logic              any_stb;
  logic [BEAT_W-1:0] shadow_lo;
  logic [BEAT_W-1:0] beat_next;

  assign any_stb   = !strobe_cpu_n || !strobe_ctl_n;
  assign beat_next = beat_o + BEAT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shadow_lo <= '0;
    else if (any_stb) shadow_lo <= base_addr[BEAT_W-1:0];
  end

  // R2
  load_takes_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |=> (beat_o == '0) && (addr_o == $past(base_addr)));

  // R3
  advance_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_stb && !adv_n) |=> beat_o == $past(beat_next));

  // R4
  hold_keeps_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_stb && adv_n) |=> $stable(beat_o));

  // R7
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_stb |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

  // R5
  xor_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !order_lin |-> addr_o[BEAT_W-1:0] == (shadow_lo ^ beat_o));

  // R6
  wrap_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    order_lin |-> addr_o[BEAT_W-1:0] == BEAT_W'(shadow_lo + beat_o));
endmodule

bind burst_addr_seq bsq_checker #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe_cpu_n(strobe_cpu_n),
  .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n), .order_lin(order_lin),
  .base_addr(base_addr), .addr_o(addr_o), .beat_o(beat_o)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 17;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stb_a_n = 1'b1;
  logic          stb_b_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          order_lin = 1'b0;
  logic [AW-1:0] base = '0;
  logic [AW-1:0] addr;
  logic [BW-1:0] beat;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_cpu_n(stb_a_n), .strobe_ctl_n(stb_b_n),
    .adv_n(adv_n), .order_lin(order_lin), .base_addr(base),
    .addr_o(addr), .beat_o(beat)
  );

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] b,
                                             input logic [BW-1:0] k,
                                             input logic lin);
    logic [BW-1:0] lo;
    lo = lin ? BW'(b[BW-1:0] + k) : (b[BW-1:0] ^ k);
    return {b[AW-1:BW], lo};
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input logic [AW-1:0] b, input logic use_b);
    base = b;
    stb_a_n = use_b;
    stb_b_n = !use_b;
    tick();
    stb_a_n = 1'b1;
    stb_b_n = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 addr", addr, '0);
    check("R1 beat", AW'(beat), '0);
  endtask

  task automatic t_load_both();
    load(17'h0ABC5, 1'b0);
    check("R2 cpu strobe addr", addr, 17'h0ABC5);
    check("R2 cpu strobe beat", AW'(beat), '0);
    load(17'h1F00E, 1'b1);
    check("R2 ctl strobe addr", addr, 17'h1F00E);
    check("R2 ctl strobe beat", AW'(beat), '0);
  endtask

  task automatic t_order(input logic lin, input logic [AW-1:0] b, input string rq);
    order_lin = lin;
    load(b, 1'b0);
    check({rq, " beat0"}, addr, exp_addr(b, 2'd0, lin));
    adv_n = 1'b0;
    for (int k = 1; k < 4; k++) begin
      tick();
      check("R3 beat step", AW'(beat), AW'(k));
      check({rq, " sequence"}, addr, exp_addr(b, BW'(k), lin));
      check("R7 upper fixed", {addr[AW-1:BW], 2'b00}, {b[AW-1:BW], 2'b00});
    end
    adv_n = 1'b1;
  endtask

  task automatic t_hold_wrap();
    logic [AW-1:0] b = 17'h15553;
    order_lin = 1'b1;
    load(b, 1'b1);
    adv_n = 1'b0;
    tick();
    adv_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R4 hold beat", AW'(beat), AW'(1));
      check("R4 hold addr", addr, exp_addr(b, 2'd1, 1'b1));
    end
    adv_n = 1'b0;
    repeat (3) tick();
    check("R9 wrap beat", AW'(beat), '0);
    check("R9 wrap addr", addr, b);
    adv_n = 1'b1;
  endtask

  task automatic t_priority();
    order_lin = 1'b0;
    load(17'h00004, 1'b0);
    adv_n = 1'b0;
    repeat (2) tick();
    base = 17'h1C3A2;
    stb_b_n = 1'b0;
    tick();
    stb_b_n = 1'b1;
    check("R8 reload beat", AW'(beat), '0);
    check("R8 reload addr", addr, 17'h1C3A2);
    tick();
    check("R8 after reload", addr, exp_addr(17'h1C3A2, 2'd1, 1'b0));
    adv_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_load_both();
    t_order(1'b0, 17'h12341, "R5");
    t_order(1'b0, 17'h0F0F3, "R5");
    t_order(1'b1, 17'h0A5A6, "R6");
    t_order(1'b1, 17'h1FFFF, "R6");
    t_hold_wrap();
    t_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule